// File: doc/BRIEF.md
# Two-Level Address Translator With Translation Buffer

This block turns a 24-bit logical address into a 24-bit physical storage address. Addresses are first looked up in an eight-entry fully associative translation buffer. On a hit the physical address comes back on the next cycle. On a miss the block walks two tables held in memory. First it reads a segment-table word, which is found from a loadable origin register. Then it reads a page-table word, which is found from the origin carried in the segment word. The result is written into the buffer and returned. A table word whose invalid flag is set ends the walk with a translation exception in place of an address.

Only one request is in flight at a time. `req_ready` is high whenever the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Table reads use a plain read port. The block holds `mem_rd_valid` and `mem_rd_addr` until a cycle in which `mem_rsp_valid` returns the 32-bit word. A buffer flush comes from the purge input or from loading a new table origin.

Top module: `xlat_top`

## Requirements
- R1: The logical address splits into segment index bits 23:20, page index bits 19:12 and byte offset bits 11:0. The offset appears unchanged in bits 11:0 of every non-exception physical address.
- R2: The segment-table word is read from address origin + 4 × segment index.
- R3: The page-table word is read from (bits 23:0 of the segment word) + 4 × page index. The physical address is {page word bits 23:12, offset}.
- R4: A request that hits a valid buffer entry with the same segment and page indices returns `rsp_valid` on the cycle after acceptance and issues no table read.
- R5: A miss with valid table words issues exactly two table reads, segment first and then page. It then returns a response, and `mem_rd_valid` is never high while `req_ready` is high.
- R6: A segment word with bit 0 set ends the walk after one read with `rsp_fault` = 1 and `rsp_paddr` = 0.
- R7: A page word with bit 0 set gives `rsp_fault` = 1 after two reads. No buffer entry is written, so a repeat of the same address walks again.
- R8: Each buffer entry has a reference bit, which is set when the entry hits or is filled. If that leaves all eight bits set, every bit except the one just touched is cleared. A fill goes to the lowest-indexed entry whose bit is clear.
- R9: A cycle with `purge` high invalidates all buffer entries, so the next request misses.
- R10: A cycle with `tbl_load` high stores `tbl_origin` as the segment-table origin and invalidates all buffer entries in that same cycle.
- R11: During and right after reset, `rsp_valid` and `mem_rd_valid` are 0 and `req_ready` is 1.
- R12: While a table read waits for `mem_rsp_valid`, `mem_rd_valid` stays high and `mem_rd_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | 24 | Logical address |
| req_ready | output | 1 | Block idle, request can be taken |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 24 | Physical address (0 on exception) |
| rsp_fault | output | 1 | Translation exception |
| tbl_load | input | 1 | Load segment-table origin and flush buffer |
| tbl_origin | input | 24 | New segment-table origin |
| purge | input | 1 | Flush buffer |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_addr | output | 24 | Table read byte address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table word |

## Verification
A stale or wrongly tagged buffer entry shows up on the very next request to that page. The response then comes one cycle after acceptance with the wrong frame, or with no table read where two were due. A corrupted reference bit is quieter: it only shows when a later fill evicts the wrong page, and that surfaces as an unexpected walk on a following request. A wrong walk state or origin shows within one walk, as a table read at the wrong address or the wrong number of reads before the response.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_SEG  = 2'd1,
      WK_PAGE = 2'd2
   } walk_st_t;
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 12,
   parameter int FRM_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             lk_en,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   output logic [FRM_W-1:0] hit_frame,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [FRM_W-1:0] fill_frame
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlat_tlb: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0] vld_q, ref_q, match, victim_oh, touch, ref_nx;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [FRM_W-1:0]   frm_q [ENTRIES];
   logic               found;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
      always_ff @(posedge clk) begin
         if (fill_en && victim_oh[g] && !flush) begin
            tag_q[g] <= fill_tag;
            frm_q[g] <= fill_frame;
         end
      end
   end

   assign hit = |match;

   always_comb begin
      hit_frame = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (match[i]) hit_frame = hit_frame | frm_q[i];
   end

   // lowest-indexed entry not referenced recently
   always_comb begin
      victim_oh = '0;
      found     = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!ref_q[i] && !found) begin
            victim_oh[i] = 1'b1;
            found        = 1'b1;
         end
      end
      if (!found) victim_oh[0] = 1'b1;
   end

   always_comb begin
      if (lk_en && hit)  touch = match;
      else if (fill_en)  touch = victim_oh;
      else               touch = '0;
      ref_nx = ref_q | touch;
      if (&ref_nx) ref_nx = touch;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         ref_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
         ref_q <= '0;
      end else begin
         ref_q <= ref_nx;
         if (fill_en) vld_q <= vld_q | victim_oh;
      end
   end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int LA_W   = 24,
   parameter int OFS_W  = 12,
   parameter int SEG_W  = 4,
   parameter int PG_W   = 8,
   parameter int PA_W   = 24,
   parameter int WORD_W = 32,
   localparam int FRM_W = PA_W - OFS_W,
   localparam int TAG_W = SEG_W + PG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [LA_W-1:0]   req_laddr,
   output logic              req_ready,
   output logic              lk_en,
   input  logic              hit,
   input  logic [FRM_W-1:0]  hit_frame,
   input  logic [PA_W-1:0]   seg_origin,
   output logic              mem_rd_valid,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [WORD_W-1:0] mem_rsp_data,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault,
   output logic              fill_en,
   output logic [TAG_W-1:0]  fill_tag,
   output logic [FRM_W-1:0]  fill_frame
);
   walk_st_t          st_q;
   logic [LA_W-1:0]   lad_q;
   logic [PA_W-1:0]   pto_q;
   logic [PA_W-1:0]   seg_addr, pg_addr;
   logic              bad_word;

   assign req_ready    = (st_q == WK_IDLE);
   assign lk_en        = req_valid && req_ready;
   assign mem_rd_valid = (st_q != WK_IDLE);
   assign bad_word     = mem_rsp_data[0];

   assign seg_addr    = seg_origin + PA_W'({lad_q[LA_W-1 -: SEG_W], 2'b00});
   assign pg_addr     = pto_q + PA_W'({lad_q[OFS_W +: PG_W], 2'b00});
   assign mem_rd_addr = (st_q == WK_PAGE) ? pg_addr : seg_addr;

   assign fill_en    = (st_q == WK_PAGE) && mem_rsp_valid && !bad_word;
   assign fill_tag   = lad_q[LA_W-1:OFS_W];
   assign fill_frame = mem_rsp_data[PA_W-1:OFS_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= WK_IDLE;
         lad_q     <= '0;
         pto_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st_q)
            WK_IDLE: if (lk_en) begin
               lad_q <= req_laddr;
               if (hit) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b0;
                  rsp_paddr <= {hit_frame, req_laddr[OFS_W-1:0]};
               end else begin
                  st_q <= WK_SEG;
               end
            end
            WK_SEG: if (mem_rsp_valid) begin
               if (bad_word) begin
                  rsp_valid <= 1'b1;
                  rsp_fault <= 1'b1;
                  rsp_paddr <= '0;
                  st_q      <= WK_IDLE;
               end else begin
                  pto_q <= mem_rsp_data[PA_W-1:0];
                  st_q  <= WK_PAGE;
               end
            end
            WK_PAGE: if (mem_rsp_valid) begin
               rsp_valid <= 1'b1;
               rsp_fault <= bad_word;
               rsp_paddr <= bad_word ? '0 :
                            {mem_rsp_data[PA_W-1:OFS_W], lad_q[OFS_W-1:0]};
               st_q      <= WK_IDLE;
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xlat_top.sv
module xlat_top #(
   parameter int LA_W    = 24,
   parameter int OFS_W   = 12,
   parameter int SEG_W   = 4,
   parameter int PG_W    = 8,
   parameter int PA_W    = 24,
   parameter int WORD_W  = 32,
   parameter int ENTRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [LA_W-1:0]   req_laddr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault,
   input  logic              tbl_load,
   input  logic [PA_W-1:0]   tbl_origin,
   input  logic              purge,
   output logic              mem_rd_valid,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [WORD_W-1:0] mem_rsp_data
);
   localparam int FRM_W = PA_W - OFS_W;
   localparam int TAG_W = SEG_W + PG_W;

   if (LA_W != SEG_W + PG_W + OFS_W) begin : g_bad_split
      $error("xlat_top: address fields do not sum to LA_W");
   end
   if (PA_W > WORD_W || PA_W <= OFS_W) begin : g_bad_pa
      $error("xlat_top: PA_W must fit in a table word and exceed OFS_W");
   end

   logic [PA_W-1:0]  origin_q;
   logic             flush, lk_en, tlb_hit, fill_en;
   logic [FRM_W-1:0] hit_frame, fill_frame;
   logic [TAG_W-1:0] fill_tag;

   assign flush = purge || tbl_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        origin_q <= '0;
      else if (tbl_load) origin_q <= tbl_origin;
   end

   xlat_tlb #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .FRM_W(FRM_W)) u_tlb (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_en(lk_en), .lk_tag(req_laddr[LA_W-1:OFS_W]),
      .hit(tlb_hit), .hit_frame(hit_frame),
      .fill_en(fill_en), .fill_tag(fill_tag), .fill_frame(fill_frame)
   );

   xlat_walker #(.LA_W(LA_W), .OFS_W(OFS_W), .SEG_W(SEG_W), .PG_W(PG_W),
                 .PA_W(PA_W), .WORD_W(WORD_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_laddr(req_laddr), .req_ready(req_ready),
      .lk_en(lk_en), .hit(tlb_hit), .hit_frame(hit_frame),
      .seg_origin(origin_q),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .fill_en(fill_en), .fill_tag(fill_tag), .fill_frame(fill_frame)
   );
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
   parameter int LA_W  = 24,
   parameter int PA_W  = 24,
   parameter int OFS_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [LA_W-1:0] req_laddr,
   input logic            tlb_hit,
   input logic            rsp_valid,
   input logic            rsp_fault,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            mem_rd_valid,
   input logic [PA_W-1:0] mem_rd_addr,
   input logic            mem_rsp_valid,
   input logic            purge,
   input logic            tbl_load
);
   assert_hit_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && tlb_hit) |=> (rsp_valid && !mem_rd_valid));

   assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && tlb_hit) |=>
         (rsp_paddr[OFS_W-1:0] == $past(req_laddr[OFS_W-1:0])));

   assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault && rsp_valid |-> (rsp_paddr == '0));

   assert_idle_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_valid && req_ready));

   assert_purge_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      purge |=> !tlb_hit);

   assert_load_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_load |=> !tlb_hit);

   assert_hold_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

bind xlat_top xlat_chk #(.LA_W(LA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_laddr(req_laddr), .tlb_hit(tlb_hit), .rsp_valid(rsp_valid),
   .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .mem_rd_valid(mem_rd_valid),
   .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
   .purge(purge), .tbl_load(tbl_load)
);

// File: tb/sim_xlat_top.sv
`timescale 1ns/1ps
module sim_xlat_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_laddr = '0;
   logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid;
   logic [23:0] rsp_paddr, mem_rd_addr;
   logic        tbl_load = 1'b0;
   logic [23:0] tbl_origin = '0;
   logic        purge = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int errors = 0;
   int checks = 0;
   int rd_cnt = 0;
   bit done = 1'b0;
   logic [23:0] rd_log [4];
   logic [23:0] origin_m = '0;

   always #10 clk = ~clk;

   xlat_top u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .tbl_load(tbl_load), .tbl_origin(tbl_origin),
      .purge(purge), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   // Table memory: segment tables at 0x00 and 0x40, page tables at 0x10000/0x20000
   function automatic logic [31:0] mem_word(input logic [23:0] a);
      logic [23:0] base;
      logic [11:0] fr;
      if (a < 24'h80) begin
         base = a[6] ? 24'h020000 : 24'h010000;
         if (a[5:2] == 4'hF) return 32'h1;
         return {8'h0, base + {10'h0, a[5:2], 10'h0}};
      end
      if (a[9:2] == 8'hFF) return 32'h1;
      fr = a[13:2] ^ ((a[17:16] == 2'b10) ? 12'h600 : 12'h300);
      return {8'h0, fr, 12'h0};
   endfunction

   always @(negedge clk) begin
      if (mem_rd_valid && !mem_rsp_valid) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= mem_word(mem_rd_addr);
      end else begin
         mem_rsp_valid <= 1'b0;
      end
   end

   always @(posedge clk) begin
      if (mem_rd_valid && mem_rsp_valid) begin
         rd_log[rd_cnt & 3] = mem_rd_addr;
         rd_cnt = rd_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_xlat(input logic [23:0] la, input bit exp_hit);
      logic [3:0]  s;
      logic [7:0]  p;
      logic [23:0] pe, exp_pa, base;
      bit          exp_f;
      int          exp_rd, cyc, r0;
      s = la[23:20];
      p = la[19:12];
      base = (origin_m == 24'h40) ? 24'h020000 : 24'h010000;
      pe = base + {10'h0, s, 10'h0} + {14'h0, p, 2'b00};
      exp_f  = (s == 4'hF) || (p == 8'hFF);
      exp_rd = exp_hit ? 0 : (s == 4'hF) ? 1 : 2;
      exp_pa = exp_f ? 24'h0 :
               {pe[13:2] ^ ((base == 24'h020000) ? 12'h600 : 12'h300), la[11:0]};
      @(negedge clk);
      r0 = rd_cnt;
      req_valid = 1'b1;
      req_laddr = la;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!rsp_valid && cyc < 60) begin
         @(negedge clk);
         cyc++;
      end
      check(rsp_valid, "R5 response arrives", {31'h0, rsp_valid}, 32'h1);
      check(rsp_fault == exp_f, exp_f ? "R6/R7 fault" : "R3 no fault",
            {31'h0, rsp_fault}, {31'h0, exp_f});
      check(rsp_paddr == exp_pa, "R1/R3 paddr", {8'h0, rsp_paddr}, {8'h0, exp_pa});
      check((cyc == 1) == exp_hit, "R4 hit latency", cyc, exp_hit ? 1 : 99);
      check(rd_cnt - r0 == exp_rd, "R5 table read count", rd_cnt - r0, exp_rd);
      if (exp_rd >= 1)
         check(rd_log[r0 & 3] == origin_m + {18'h0, s, 2'b00}, "R2 segment read addr",
               {8'h0, rd_log[r0 & 3]}, {8'h0, origin_m + {18'h0, s, 2'b00}});
      if (exp_rd == 2)
         check(rd_log[(r0 + 1) & 3] == pe, "R3 page read addr",
               {8'h0, rd_log[(r0 + 1) & 3]}, {8'h0, pe});
   endtask

   // {expect hit, logical address}
   localparam logic [24:0] VEC [8] = '{
      {1'b0, 24'h312ABC}, {1'b1, 24'h312004}, {1'b0, 24'h7FF123}, {1'b0, 24'hF00000},
      {1'b0, 24'h7FF000}, {1'b0, 24'h000FFF}, {1'b1, 24'h312FFF}, {1'b0, 24'hE01010}
   };

   initial begin
      repeat (2) @(negedge clk);
      check(!rsp_valid, "R11 rsp_valid in reset", {31'h0, rsp_valid}, 0);
      check(!mem_rd_valid, "R11 mem_rd_valid in reset", {31'h0, mem_rd_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R11 ready after reset", {31'h0, req_ready}, 1);
      check(!rsp_valid, "R11 rsp_valid after reset", {31'h0, rsp_valid}, 0);

      foreach (VEC[i]) do_xlat(VEC[i][23:0], VEC[i][24]);

      // R9: purge forgets cached page
      @(negedge clk); purge = 1'b1;
      @(negedge clk); purge = 1'b0;
      do_xlat(24'h312000, 1'b0);
      do_xlat(24'h312000, 1'b1);

      // R8: replacement order
      @(negedge clk); purge = 1'b1;
      @(negedge clk); purge = 1'b0;
      for (int k = 0; k < 8; k++) do_xlat({4'h1, 8'(k), 12'h010}, 1'b0);
      do_xlat(24'h100020, 1'b1);   // entry 0 hit
      do_xlat(24'h108030, 1'b0);   // fills entry 1, evicting page 1
      do_xlat(24'h100040, 1'b1);   // R8 page 0 kept
      do_xlat(24'h107040, 1'b1);   // R8 page 7 kept
      do_xlat(24'h101050, 1'b0);   // R8 page 1 evicted

      // R10: new origin, buffer flushed
      @(negedge clk); tbl_load = 1'b1; tbl_origin = 24'h000040;
      @(negedge clk); tbl_load = 1'b0; origin_m = 24'h000040;
      do_xlat(24'h312000, 1'b0);
      do_xlat(24'h312777, 1'b1);
      do_xlat(24'hF12000, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule